// File: doc/BRIEF.md
# Interleaved Reed-Solomon Frame Encoder

This block adds forward error correction to a fixed 120-bit line frame. An 88-bit message (header and payload together) arrives with a one-cycle valid strobe. The message is cut into 22 four-bit symbols, and these are dealt alternately to two independent Reed-Solomon RS(15,11) codewords over GF(16). Each codeword receives four parity symbols, so the frame carries 32 parity bits. Because the symbols of the two codewords alternate, a burst that corrupts up to four adjacent symbols (16 bits) damages at most two symbols of each codeword, and a matching decoder can correct all of it. About 70% of the frame remains useful data once the line coding is added.

The encoder is systematic. The message passes through unchanged into the upper 88 bits of the frame, and the two parity sets fill the lower 32 bits, interleaved in the same alternating way. Internally, one symbol-serial polynomial divider per codeword takes one symbol each clock. After a fixed 11-cycle latency the block raises its output strobe for one cycle. The frame then stays on the output until the next message is accepted.

Top module: `rs_frame_enc`

## Requirements
- R1: Arithmetic is in GF(16) with field polynomial x^4+x+1, and alpha = 2. Each codeword's parity p(x) is the remainder of m(x)·x^4 divided by g(x) = (x+α)(x+α²)(x+α³)(x+α⁴).
- R2: Message symbol j (j = 0..21) is in_msg[87-4j -: 4]. Even j goes to codeword A and odd j goes to codeword B. Within a codeword, the symbol received first is the coefficient of the highest power, x^14.
- R3: out_frame[119:32] equals the accepted in_msg, bit for bit.
- R4: In out_frame[31:0], the parity symbol of degree d belongs at bits [31-4·((3-d)·2+L) -: 4], where L is 0 for codeword A and 1 for codeword B. The highest-degree parity of A sits at [31:28] and the lowest-degree parity of B sits at [3:0].
- R5: Both reassembled 15-symbol codewords of a valid frame evaluate to zero at α, α², α³ and α⁴.
- R6: When in_valid is accepted at clock edge k, out_valid is high for exactly the one cycle that follows edge k+11, whatever the data.
- R7: A strobe at edges k+1 through k+11 is ignored, and it changes neither the message field nor the produced frame. A strobe at edge k+12 or later is accepted.
- R8: Between its out_valid pulse and the next accepted strobe, out_frame holds its value.
- R9: While rst_n is low, out_valid is 0 and out_frame is all zeros.
- R10: An all-zero message produces an all-zero frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Message strobe, sampled when the encoder is idle |
| in_msg | input | 88 | Message bits, first symbol in the top nibble |
| out_valid | output | 1 | One-cycle pulse marking a complete coded frame |
| out_frame | output | 120 | Message in bits 119:32, interleaved parity in bits 31:0 |

## Verification
The bound checker tracks the acceptance window with its own counter, and on every cycle it checks several timing properties:
- the fixed 11-cycle latency and the single-cycle output pulse;
- the rejection of strobes while a frame is in progress;
- the stability of the message field during that window and of the whole frame while idle;
- the one-symbol-per-cycle stepping of the dividers.

The arithmetic cannot be covered by these properties. The parity values, the even/odd symbol dealing, the parity bit placement and the zero syndromes can be seen only in the bench's scenarios. There, every frame is compared against an independent long-division model, and the syndromes are evaluated on the frame as received.

// File: rtl/rsfec_pkg.sv
package rsfec_pkg;
  localparam int SYM_W   = 4;
  localparam int NPAR    = 4;
  localparam int K_SYM   = 11;
  localparam int ILV     = 2;
  localparam logic [SYM_W:0] FIELD_POLY = 5'b10011;

  localparam int MSG_W   = SYM_W * K_SYM * ILV;
  localparam int PAR_W   = SYM_W * NPAR * ILV;
  localparam int FRAME_W = MSG_W + PAR_W;
  localparam int STEP_W  = $clog2(K_SYM);

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [NPAR:0]    gpoly_t;
  typedef sym_t [NPAR-1:0]  par_t;

  // Carry-less multiply with reduction by the field polynomial
  function automatic sym_t gf_mul(input sym_t a, input sym_t b);
    sym_t acc;
    sym_t sh;
    logic top;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      top = sh[SYM_W-1];
      sh  = sh << 1;
      if (top) sh = sh ^ FIELD_POLY[SYM_W-1:0];
    end
    return acc;
  endfunction

  // Product of (x + alpha^i), i = 1..NPAR; index = power of x
  function automatic gpoly_t gen_poly();
    gpoly_t g;
    sym_t   root;
    g    = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 1; i <= NPAR; i++) begin
      root = gf_mul(root, sym_t'(2));
      for (int k = i; k >= 1; k--) g[k] = g[k-1] ^ gf_mul(root, g[k]);
      g[0] = gf_mul(root, g[0]);
    end
    return g;
  endfunction
endpackage

// File: rtl/rs_lfsr_div.sv
module rs_lfsr_div
  import rsfec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  sym_t sym_in,
  output par_t rem
);
  localparam gpoly_t GEN = gen_poly();

  sym_t fb;
  par_t nxt;

  assign fb = sym_in ^ rem[NPAR-1];

  generate
    for (genvar k = 0; k < NPAR; k++) begin : g_stage
      if (k == 0) begin : g_low
        assign nxt[k] = gf_mul(GEN[k], fb);
      end else begin : g_up
        assign nxt[k] = rem[k-1] ^ gf_mul(GEN[k], fb);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)   rem <= '0;
    else if (clr) rem <= '0;
    else if (en)  rem <= nxt;
  end
endmodule

// File: rtl/rs_lane_tap.sv
module rs_lane_tap
  import rsfec_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic [MSG_W-1:0]  msg,
  input  logic [STEP_W-1:0] step,
  output sym_t              sym
);
  logic [MSG_W-1:0] shifted;

  always_comb begin
    shifted = msg << (SYM_W * (ILV * int'(step) + LANE));
    sym     = shifted[MSG_W-1 -: SYM_W];
  end
endmodule

// File: rtl/rs_enc_seq.sv
module rs_enc_seq
  import rsfec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              acc_fire,
  output logic              step_en,
  output logic [STEP_W-1:0] step_idx,
  output logic              last_step,
  output logic              out_valid
);
  logic busy;

  assign acc_fire  = in_valid & ~busy;
  assign step_en   = busy;
  assign last_step = busy && (step_idx == STEP_W'(K_SYM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step_idx  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= last_step;
      if (acc_fire) begin
        busy     <= 1'b1;
        step_idx <= '0;
      end else if (last_step) begin
        busy     <= 1'b0;
        step_idx <= '0;
      end else if (busy) begin
        step_idx <= step_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_frame_enc.sv
module rs_frame_enc
  import rsfec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [MSG_W-1:0]   in_msg,
  output logic               out_valid,
  output logic [FRAME_W-1:0] out_frame
);
  logic              acc_fire;
  logic              step_en;
  logic              last_step;
  logic [STEP_W-1:0] step_idx;
  logic [MSG_W-1:0]  msg_q;
  logic [PAR_W-1:0]  par_bits;
  sym_t              lane_sym [ILV];
  par_t              lane_par [ILV];

  rs_enc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .acc_fire  (acc_fire),
    .step_en   (step_en),
    .step_idx  (step_idx),
    .last_step (last_step),
    .out_valid (out_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        msg_q <= '0;
    else if (acc_fire) msg_q <= in_msg;
  end

  generate
    for (genvar l = 0; l < ILV; l++) begin : g_lane
      rs_lane_tap #(.LANE(l)) u_tap (
        .msg  (msg_q),
        .step (step_idx),
        .sym  (lane_sym[l])
      );
      rs_lfsr_div u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_fire),
        .en     (step_en),
        .sym_in (lane_sym[l]),
        .rem    (lane_par[l])
      );
    end
  endgenerate

  // Parity symbols alternate between lanes, highest degree first
  always_comb begin
    par_bits = '0;
    for (int l = 0; l < ILV; l++) begin
      for (int d = 0; d < NPAR; d++) begin
        par_bits[PAR_W-1 - SYM_W*((NPAR-1-d)*ILV + l) -: SYM_W] = lane_par[l][d];
      end
    end
  end

  assign out_frame = {msg_q, par_bits};
endmodule

// File: rtl/rs_frame_enc_chk.sv
module rs_frame_enc_chk
  import rsfec_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [MSG_W-1:0]   in_msg,
  input logic               out_valid,
  input logic [FRAME_W-1:0] out_frame,
  input logic               acc_fire,
  input logic [STEP_W-1:0]  step_idx
);
  logic [STEP_W:0] win;

  always_ff @(posedge clk) begin
    if (!rst_n)                                      win <= '0;
    else if (acc_fire)                               win <= (STEP_W+1)'(1);
    else if (win != '0 && win != (STEP_W+1)'(K_SYM)) win <= win + 1'b1;
    else                                             win <= '0;
  end

  AST_LATENCY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (win == (STEP_W+1)'(K_SYM)) |=> out_valid); // R6
  AST_NO_STRAY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(win) == (STEP_W+1)'(K_SYM))); // R6
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> !acc_fire); // R7
  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |=> $stable(out_frame[FRAME_W-1:PAR_W])); // R7
  AST_SYSTEMATIC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> (out_frame[FRAME_W-1:PAR_W] == $past(in_msg))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win == '0 && !in_valid) |=> $stable(out_frame)); // R8
  AST_STEP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    (win != '0) |-> (step_idx == STEP_W'(win - 1'b1))); // R2
endmodule

bind rs_frame_enc rs_frame_enc_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_msg    (in_msg),
  .out_valid (out_valid),
  .out_frame (out_frame),
  .acc_fire  (acc_fire),
  .step_idx  (step_idx)
);

// File: tb/test_rs_frame_enc.sv
module test_rs_frame_enc;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [87:0]  in_msg = '0;
  logic         out_valid;
  logic [119:0] out_frame;

  int n_vec = 0;
  int n_bad = 0;
  int exp_t [15];
  int log_t [16];
  int gen_c [5];

  rs_frame_enc i_rs_frame_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .out_valid (out_valid),
    .out_frame (out_frame)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int gmul(input int a, input int b);
    if (a == 0 || b == 0) return 0;
    return exp_t[(log_t[a] + log_t[b]) % 15];
  endfunction

  task automatic check(input bit ok, input string req, input logic [119:0] act, input logic [119:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [119:0] ref_frame(input logic [87:0] m);
    logic [119:0] f;
    int w [15];
    f = {m, 32'b0};
    for (int lane = 0; lane < 2; lane++) begin
      for (int i = 0; i < 15; i++) w[i] = 0;
      for (int i = 0; i < 11; i++) w[14-i] = int'(m[87-4*(2*i+lane) -: 4]);
      for (int deg = 14; deg >= 4; deg--) begin
        int c;
        c = w[deg];
        if (c != 0)
          for (int j = 0; j <= 4; j++) w[deg-4+j] = w[deg-4+j] ^ gmul(c, gen_c[j]);
      end
      for (int d = 0; d < 4; d++) f[31-4*((3-d)*2+lane) -: 4] = w[d][3:0];
    end
    return f;
  endfunction

  function automatic bit syn_zero(input logic [119:0] f, input int lane);
    int c [15];
    for (int i = 0; i < 11; i++) c[14-i] = int'(f[119-4*(2*i+lane) -: 4]);
    for (int d = 0; d < 4; d++)  c[d]    = int'(f[31-4*((3-d)*2+lane) -: 4]);
    for (int r = 1; r <= 4; r++) begin
      int s;
      s = 0;
      for (int k = 0; k < 15; k++) s = s ^ gmul(c[k], exp_t[(r*k) % 15]);
      if (s != 0) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [15:0] lane_par(input logic [119:0] f, input int lane);
    logic [15:0] p;
    for (int d = 0; d < 4; d++) p[4*d +: 4] = f[31-4*((3-d)*2+lane) -: 4];
    return p;
  endfunction

  task automatic strobe(input logic [87:0] m);
    @(negedge clk);
    in_valid = 1'b1;
    in_msg   = m;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // One message end to end; checks R1 R3 R4 R5 R6 R8
  task automatic t_encode(input logic [87:0] m);
    logic [119:0] exp_f;
    logic [119:0] held;
    int lat;
    exp_f = ref_frame(m);
    strobe(m);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(lat == LAT, "R6 latency", 120'(lat), 120'(LAT));
    check(out_frame[119:32] == m, "R3 message field", out_frame, exp_f);
    check(out_frame[31:0] == exp_f[31:0], "R1 R4 parity", out_frame, exp_f);
    check(syn_zero(out_frame, 0), "R5 syndromes A", out_frame, exp_f);
    check(syn_zero(out_frame, 1), "R5 syndromes B", out_frame, exp_f);
    held = out_frame;
    @(negedge clk);
    check(!out_valid, "R6 single pulse", 120'(out_valid), 120'(0));
    repeat (3) @(negedge clk);
    check(out_frame == held, "R8 frame held", out_frame, held);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && out_frame == '0, "R9 reset state", out_frame, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_zero;
    t_encode('0);
    check(out_frame == '0, "R10 zero frame", out_frame, '0);
  endtask

  task automatic t_order;
    logic [87:0] m;
    m = '0;
    m[87:84] = 4'h1;
    t_encode(m);
    check(lane_par(out_frame, 0) != 16'h0, "R2 first symbol in A", 120'(lane_par(out_frame, 0)), 120'(1));
    check(lane_par(out_frame, 1) == 16'h0, "R2 B untouched", 120'(lane_par(out_frame, 1)), '0);
    m = '0;
    m[83:80] = 4'h9;
    t_encode(m);
    check(lane_par(out_frame, 0) == 16'h0, "R2 A untouched", 120'(lane_par(out_frame, 0)), '0);
    check(lane_par(out_frame, 1) != 16'h0, "R2 second symbol in B", 120'(lane_par(out_frame, 1)), 120'(1));
    m = '0;
    m[3:0] = 4'h5;
    t_encode(m);
  endtask

  task automatic t_patterns;
    t_encode({22{4'hF}});
    t_encode({11{8'hA5}});
    t_encode(88'h0123456789ABCDEF_FEDCBA);
    for (int i = 0; i < 12; i++) begin
      logic [95:0] r;
      r = {$urandom(), $urandom(), $urandom()};
      t_encode(r[87:0]);
    end
  endtask

  task automatic t_busy;
    logic [87:0] ma;
    logic [87:0] mb;
    bit early;
    ma = 88'hDEADBEEF_0BADF00D_C0FFEE;
    mb = 88'h13579BDF_2468ACE0_F1E2D3;
    @(negedge clk);
    in_valid = 1'b1;
    in_msg   = ma;
    @(negedge clk);
    in_msg = mb;
    early  = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (out_valid) early = 1'b1;
      @(negedge clk);
    end
    if (out_valid) early = 1'b1;
    check(!early, "R7 no output during window", 120'(early), '0);
    @(negedge clk);
    check(out_valid && out_frame == ref_frame(ma), "R7 first frame kept", out_frame, ref_frame(ma));
    @(negedge clk);
    in_valid = 1'b0;
    check(!out_valid, "R6 pulse ends", 120'(out_valid), '0);
    repeat (LAT) @(negedge clk);
    check(out_valid && out_frame == ref_frame(mb), "R7 strobe at k+12 accepted", out_frame, ref_frame(mb));
    @(negedge clk);
  endtask

  initial begin
    int v;
    v = 1;
    for (int i = 0; i < 15; i++) begin
      exp_t[i] = v;
      log_t[v] = i;
      v = v << 1;
      if ((v & 16) != 0) v = v ^ 19;
    end
    log_t[0] = 0;
    gen_c = '{1, 0, 0, 0, 0};
    for (int i = 1; i <= 4; i++) begin
      int r;
      r = exp_t[i];
      for (int k = i; k >= 1; k--) gen_c[k] = gen_c[k-1] ^ gmul(r, gen_c[k]);
      gen_c[0] = gmul(r, gen_c[0]);
    end
    t_reset;
    t_zero;
    t_order;
    t_patterns;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule